// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI bus master that a processor drives through a small word-addressed register bus. Software first clears the enable register. It then programs the clock divisor, the frame format (clock polarity, clock phase, 8- or 16-bit frames) and the number of frames minus one. It writes words into a 32-entry transmit queue, drives a one-hot chip-select register, and sets the enable bit. The core then exchanges exactly the programmed number of frames, most significant bit first. Every frame it sends captures one frame into a 32-entry receive queue. When the last frame is done, the core returns to idle.

Software moves data by polling a status word that carries busy, transmit-queue-full and receive-queue-empty. The engine never loses or overwrites data. It pauses with SCLK at its idle level when the transmit queue runs dry, and it waits before starting a frame while the receive queue is full. To start a new run of frames, software writes the enable bit to zero and then to one.

Register map (word address on `busAddr`): 0 format (bit0 CPOL, bit1 CPHA, bit2 16-bit frames), 1 frame count minus one (bits 15:0), 2 enable (bit0), 3 chip select (one bit per line), 4 divisor (bits 15:0), 5 status (bit0 busy, bit1 transmit full, bit2 receive empty, read only), 6 transmit data (write pushes), 7 receive data (read pops, data in the low bits).

Top module: `spim_core`

## Requirements
- R1: After reset the status word reads busy 0, transmit full 0 and receive empty 1. All chip-select outputs are high, SCLK is low, and the format, frame-count and divisor registers read 0.
- R2: Writes to the format, frame-count and divisor registers are ignored while enable is 1 and take effect while enable is 0. All three read back their stored values.
- R3: A 0-to-1 write of enable with frame count C runs exactly C+1 frames. Busy then drops, and it drops only after the last received word is in the receive queue.
- R4: With divisor D, each SCLK half period lasts H clock cycles, where H = 1 when D < 2 and H = floor(D/2) otherwise.
- R5: SCLK rests at the CPOL level whenever no frame bit is being clocked, including between frames.
- R6: With CPHA 0, MOSI is valid before the leading edge and both sides sample on the leading edge. With CPHA 1, MOSI changes on the leading edge and both sides sample on the trailing edge. Bits go MSB first. An 8-bit frame sends transmit bits 7:0 and returns the received byte in bits 7:0 with zeros above.
- R7: Chip-select output n is driven low exactly when bit n of the select register is 1. Writing 0 raises all of them, and the level holds across frames until software rewrites it.
- R8: The first SCLK edge of a run comes 2H+1 clock cycles after the clock edge that captures the enable write, provided the transmit queue already holds data.
- R9: Transmit full reads 1 with 32 words queued. Receive empty reads 0 while received words remain and 1 once all have been popped.
- R10: While frames remain and the transmit queue is empty, busy stays 1, SCLK stays idle and no frame starts, until a word is pushed.
- R11: While the receive queue holds 32 words, no new frame starts and no received word is lost. Popping lets the run finish in order.
- R12: Writing enable to 0 in the middle of a frame stops the engine at once. Busy drops and SCLK returns to its idle level with no further edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busSel is high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 4 | Active-low chip selects |

## Verification
The bench builds the core with its default parameters: 32-entry queues, four selects, 16-bit maximum frame and 16-bit divisor and count fields. At these values, a divisor of 0 gives a half period of one cycle, so filling the receive queue to 32 entries and holding it full takes only a few hundred cycles. A bus-functional SPI slave on select 0 samples and drives data by the programmed mode. This covers all four modes, both frame widths, odd and sub-minimum divisors, the exact lead-in cycle count, and the stall cases at both queue boundaries.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [2:0] ADDR_FMT    = 3'd0;
  localparam logic [2:0] ADDR_FRAMES = 3'd1;
  localparam logic [2:0] ADDR_EN     = 3'd2;
  localparam logic [2:0] ADDR_SEL    = 3'd3;
  localparam logic [2:0] ADDR_DIV    = 3'd4;
  localparam logic [2:0] ADDR_STAT   = 3'd5;
  localparam logic [2:0] ADDR_TX     = 3'd6;
  localparam logic [2:0] ADDR_RX     = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOAD,
    ST_SHIFT,
    ST_PUSH
  } spimState_t;

  // strobes and static format from control to datapath
  typedef struct packed {
    logic loadFrame;
    logic leadEdge;
    logic trailEdge;
    logic abort;
    logic inFrame;
    logic cpol;
    logic cpha;
    logic wide;
  } spimStrobe_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic             doPush, doPop;

  assign full   = (count == (PTR_W+1)'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the depth
  p_fifo_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= (PTR_W+1)'(DEPTH));

  // R11: a push against a full queue leaves the stored level unchanged
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full);

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int DIV_W   = 16,
  parameter int CNT_W   = 16,
  parameter int FRAME_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [2:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                txPush,
  output logic                rxPop,
  input  logic                txFull,
  input  logic                txEmpty,
  input  logic                rxFull,
  input  logic                rxEmpty,
  input  logic [FRAME_W-1:0]  rxData,
  output logic                txPop,
  output logic                rxPush,
  output spimStrobe_t         st,
  output logic [NUM_CS-1:0]   selOut
);
  localparam int HALF_W = DIV_W - 1;
  localparam int EDGE_W = $clog2(2 * FRAME_W);

  logic [2:0]        fmtReg;
  logic [CNT_W-1:0]  frameReg;
  logic [DIV_W-1:0]  divReg;
  logic [NUM_CS-1:0] selReg;
  logic              enReg;

  spimState_t        state;
  logic [HALF_W-1:0] halfCnt, halfLen;
  logic [EDGE_W-1:0] edgeCnt, lastEdge;
  logic [CNT_W-1:0]  remaining;
  logic              wr, rd, start, stop, tick, canLoad, busy;
  logic              unusedWdata;

  assign unusedWdata = ^busWdata;
  assign wr    = busSel && busWrite;
  assign rd    = busSel && !busWrite;
  assign start = wr && (busAddr == ADDR_EN) && busWdata[0] && !enReg;
  assign stop  = wr && (busAddr == ADDR_EN) && !busWdata[0] && enReg;

  assign txPush = wr && (busAddr == ADDR_TX);
  assign rxPop  = rd && (busAddr == ADDR_RX);

  assign halfLen  = (divReg < DIV_W'(2)) ? HALF_W'(1) : divReg[DIV_W-1:1];
  assign tick     = (halfCnt == halfLen - 1'b1);
  assign lastEdge = fmtReg[2] ? EDGE_W'(2*FRAME_W-1) : EDGE_W'(FRAME_W-1);
  assign canLoad  = !txEmpty && !rxFull;
  assign busy     = (state != ST_IDLE);

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg   <= '0;
      frameReg <= '0;
      divReg   <= '0;
      selReg   <= '0;
      enReg    <= 1'b0;
    end else if (wr) begin
      case (busAddr)
        ADDR_FMT:    if (!enReg) fmtReg   <= busWdata[2:0];
        ADDR_FRAMES: if (!enReg) frameReg <= busWdata[CNT_W-1:0];
        ADDR_DIV:    if (!enReg) divReg   <= busWdata[DIV_W-1:0];
        ADDR_SEL:    selReg <= busWdata[NUM_CS-1:0];
        ADDR_EN:     enReg  <= busWdata[0];
        default:     ;
      endcase
    end
  end

  // frame sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      edgeCnt   <= '0;
      remaining <= '0;
    end else if (stop) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= ST_LEAD;
          halfCnt   <= '0;
          remaining <= frameReg;
        end
        ST_LEAD: begin
          if (tick) begin
            state   <= ST_LOAD;
            halfCnt <= '0;
          end else halfCnt <= halfCnt + 1'b1;
        end
        ST_LOAD: if (canLoad) begin
          state   <= ST_SHIFT;
          halfCnt <= '0;
          edgeCnt <= '0;
        end
        ST_SHIFT: begin
          if (tick) begin
            halfCnt <= '0;
            if (edgeCnt == lastEdge) state <= ST_PUSH;
            else edgeCnt <= edgeCnt + 1'b1;
          end else halfCnt <= halfCnt + 1'b1;
        end
        ST_PUSH: begin
          if (remaining == '0) state <= ST_IDLE;
          else begin
            remaining <= remaining - 1'b1;
            state     <= ST_LOAD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign txPop  = (state == ST_LOAD) && canLoad && !stop;
  assign rxPush = (state == ST_PUSH) && !stop;

  always_comb begin
    st.loadFrame = txPop;
    st.leadEdge  = (state == ST_SHIFT) && tick && !edgeCnt[0] && !stop;
    st.trailEdge = (state == ST_SHIFT) && tick &&  edgeCnt[0] && !stop;
    st.abort     = stop;
    st.inFrame   = (state == ST_SHIFT);
    st.cpol      = fmtReg[0];
    st.cpha      = fmtReg[1];
    st.wide      = fmtReg[2];
  end

  assign selOut = selReg;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_FMT:    busRdata = 32'(fmtReg);
      ADDR_FRAMES: busRdata = 32'(frameReg);
      ADDR_EN:     busRdata = 32'(enReg);
      ADDR_SEL:    busRdata = 32'(selReg);
      ADDR_DIV:    busRdata = 32'(divReg);
      ADDR_STAT:   busRdata = {29'b0, rxEmpty, txFull, busy};
      ADDR_RX:     busRdata = 32'(rxData);
      default:     busRdata = '0;
    endcase
  end

  // R2: configuration is frozen while enabled
  p_cfg_locked_r2: assert property (@(posedge clk) disable iff (!rstN)
    enReg |=> ($stable(fmtReg) && $stable(frameReg) && $stable(divReg)));

  // R3: busy ends only after the final push or an abort
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(rxPush) || $past(stop)));

  // R11: a received word is never pushed into a full queue
  p_rx_no_overwrite_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  // R10: no frame is loaded from an empty transmit queue
  p_tx_underrun_r10: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  spimStrobe_t        st,
  input  logic [FRAME_W-1:0] txWord,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [FRAME_W-1:0] rxWord
);
  localparam int HALF_F = FRAME_W / 2;

  logic [FRAME_W-1:0] shReg, rxSh, aligned;
  logic               mosiReg, phase;

  assign aligned = st.wide ? txWord : {txWord[HALF_F-1:0], {HALF_F{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      rxSh    <= '0;
      mosiReg <= 1'b0;
      phase   <= 1'b0;
    end else if (st.abort) begin
      phase <= 1'b0;
    end else if (st.loadFrame) begin
      rxSh <= '0;
      if (!st.cpha) begin
        mosiReg <= aligned[FRAME_W-1];
        shReg   <= aligned << 1;
      end else begin
        shReg <= aligned;
      end
    end else if (st.leadEdge) begin
      phase <= 1'b1;
      if (!st.cpha) rxSh <= {rxSh[FRAME_W-2:0], miso};
      else begin
        mosiReg <= shReg[FRAME_W-1];
        shReg   <= shReg << 1;
      end
    end else if (st.trailEdge) begin
      phase <= 1'b0;
      if (st.cpha) rxSh <= {rxSh[FRAME_W-2:0], miso};
      else begin
        mosiReg <= shReg[FRAME_W-1];
        shReg   <= shReg << 1;
      end
    end
  end

  assign sclk   = st.cpol ^ phase;
  assign mosi   = mosiReg;
  assign rxWord = st.wide ? rxSh : {{HALF_F{1'b0}}, rxSh[HALF_F-1:0]};

  // R5: outside a frame the clock sits at its idle level
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !st.inFrame |-> !phase);

  // R6: leading edges leave the idle level, trailing edges return to it
  p_edge_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.leadEdge |-> !phase);

  p_trail_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.trailEdge |-> phase);

endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int NUM_CS     = 4,
  parameter int DIV_W      = 16,
  parameter int CNT_W      = 16,
  parameter int FRAME_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [2:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);
  spimStrobe_t        st;
  logic               txPush, txPop, rxPush, rxPop;
  logic               txFull, txEmpty, rxFull, rxEmpty;
  logic [FRAME_W-1:0] txWord, rxWord, rxData;
  logic [NUM_CS-1:0]  selOut;

  spim_ctrl #(
    .NUM_CS(NUM_CS), .DIV_W(DIV_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .txPush(txPush), .rxPop(rxPop),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxData(rxData), .txPop(txPop), .rxPush(rxPush),
    .st(st), .selOut(selOut)
  );

  spim_dp #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .txWord(txWord), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rxWord(rxWord)
  );

  spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .push(txPush), .wdata(busWdata[FRAME_W-1:0]),
    .pop(txPop), .rdata(txWord), .full(txFull), .empty(txEmpty)
  );

  spim_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(rxPush), .wdata(rxWord),
    .pop(rxPop), .rdata(rxData), .full(rxFull), .empty(rxEmpty)
  );

  assign csN = ~selOut;

endmodule

// File: tb/spim_core_bench.sv
module spim_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sclk, mosi, miso;
  logic [3:0]  csN;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_core u_spim_core (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // ---------------- SPI slave model on select 0 ----------------
  logic        tbCpol = 1'b0, tbCpha = 1'b0, tbWide = 1'b0;
  logic [15:0] slvSeed = 16'h0000;
  int          slvEdges = 0, slvBits = 0, slvFrame = 0, slvEdgeTotal = 0;
  logic [15:0] slvRx = '0;
  logic [15:0] slvCap [64];

  function automatic logic [15:0] slvWord(int f);
    logic [15:0] w;
    w = 16'hC3A5 ^ 16'(f * 16'h1111) ^ slvSeed;
    return tbWide ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] txPat(int v, int i);
    logic [15:0] w;
    w = 16'(16'h9B17 + i * 16'h02D3 + v * 16'h00F1);
    return tbWide ? w : {8'h00, w[7:0]};
  endfunction

  always @(sclk) begin
    if (rstN && !csN[0]) begin
      int nb;
      logic leading;
      nb = tbWide ? 16 : 8;
      leading = (sclk != tbCpol);
      slvEdgeTotal++;
      if (leading ^ tbCpha) begin
        slvRx = {slvRx[14:0], mosi};
        slvBits++;
        if (slvBits == nb) begin
          if (slvFrame < 64) slvCap[slvFrame] = tbWide ? slvRx : {8'h00, slvRx[7:0]};
          slvFrame++;
          slvBits = 0;
        end
      end
      slvEdges++;
      if (slvEdges == 2 * nb) slvEdges = 0;
    end
  end

  always @* begin
    int nb, idx;
    logic [15:0] w;
    nb = tbWide ? 16 : 8;
    w  = slvWord(slvFrame);
    if (!tbCpha) idx = slvEdges / 2;
    else idx = (slvEdges == 0) ? 0 : (slvEdges - 1) / 2;
    if (idx > nb - 1) idx = nb - 1;
    miso = w[nb - 1 - idx];
  end

  task automatic slaveReset();
    slvEdges = 0; slvBits = 0; slvFrame = 0; slvRx = '0; slvEdgeTotal = 0;
  endtask

  // ---------------- bus and check helpers ----------------
  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      busRd(3'd5, s);
      if (!s[0]) break;
    end
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       wide;
    logic [7:0] div;
    logic [7:0] nm1;
    logic [7:0] half;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b0, 1'b0, 8'd4, 8'd2, 8'd2},
    '{1'b0, 1'b1, 1'b1, 8'd0, 8'd1, 8'd1},
    '{1'b1, 1'b0, 1'b0, 8'd7, 8'd0, 8'd3},
    '{1'b1, 1'b1, 1'b1, 8'd3, 8'd3, 8'd1}
  };

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRd(3'd5, d); checkEq("R1 status", d, 32'h4);
    checkEq("R1 csN", 32'(csN), 32'hF);
    checkEq("R1 sclk", 32'(sclk), 32'h0);
    busRd(3'd0, d); checkEq("R1 fmt", d, 32'h0);
    busRd(3'd1, d); checkEq("R1 frames", d, 32'h0);
    busRd(3'd4, d); checkEq("R1 div", d, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    foreach (VECS[v]) begin
      busWr(3'd3, 32'h0);
      busWr(3'd2, 32'h0);
      busWr(3'd0, {29'b0, VECS[v].wide, VECS[v].cpha, VECS[v].cpol});
      busWr(3'd4, 32'(VECS[v].div));
      busWr(3'd1, 32'(VECS[v].nm1));
      tbCpol = VECS[v].cpol; tbCpha = VECS[v].cpha; tbWide = VECS[v].wide;
      slvSeed = 16'(v * 16'h0707);
      slaveReset();
      for (int i = 0; i <= int'(VECS[v].nm1); i++) busWr(3'd6, 32'(txPat(v, i)));
      busWr(3'd3, 32'h1);
      checkEq("R7 select low", 32'(csN), 32'hE);
      checkEq("R5 idle level", 32'(sclk), 32'(VECS[v].cpol));
      busWr(3'd2, 32'h1);
      k = 0;
      do begin @(negedge clk); k++; end while (sclk == VECS[v].cpol && k < 200);
      checkEq("R8 lead cycles", k, 2 * int'(VECS[v].half) + 1);
      m = 0;
      do begin @(negedge clk); m++; end while (sclk != VECS[v].cpol && m < 200);
      checkEq("R4 half period", m, int'(VECS[v].half));
      waitIdle();
      checkEq("R3 frame count", slvFrame, int'(VECS[v].nm1) + 1);
      checkEq("R5 idle after", 32'(sclk), 32'(VECS[v].cpol));
      checkEq("R7 select held", 32'(csN), 32'hE);
      busRd(3'd5, d); checkEq("R9 rx not empty", 32'(d[2]), 32'h0);
      for (int i = 0; i <= int'(VECS[v].nm1); i++) begin
        checkEq("R6 mosi frame", 32'(slvCap[i]), 32'(txPat(v, i)));
        busRd(3'd7, d);
        checkEq("R6 miso frame", d, 32'(slvWord(i)));
      end
      busRd(3'd5, d); checkEq("R9 rx empty", 32'(d[2]), 32'h1);
    end

    // R2 config locked while enabled
    busWr(3'd2, 32'h0);
    busWr(3'd0, 32'h0); busWr(3'd4, 32'd2); busWr(3'd1, 32'd0);
    busWr(3'd2, 32'h1);
    busWr(3'd0, 32'h7); busWr(3'd4, 32'd50); busWr(3'd1, 32'd99);
    busRd(3'd0, d); checkEq("R2 fmt locked", d, 32'h0);
    busRd(3'd4, d); checkEq("R2 div locked", d, 32'd2);
    busRd(3'd1, d); checkEq("R2 frames locked", d, 32'd0);
    busWr(3'd2, 32'h0);
    busWr(3'd0, 32'h4); busWr(3'd4, 32'd9); busWr(3'd1, 32'hFFFF);
    busRd(3'd0, d); checkEq("R2 fmt written", d, 32'h4);
    busRd(3'd4, d); checkEq("R2 div written", d, 32'd9);
    busRd(3'd1, d); checkEq("R2 frames written", d, 32'hFFFF);

    // R10 transmit underrun pause
    busWr(3'd0, 32'h0); busWr(3'd4, 32'd2); busWr(3'd1, 32'd1);
    tbCpol = 0; tbCpha = 0; tbWide = 0; slvSeed = 16'h1234; slaveReset();
    busWr(3'd6, 32'(txPat(9, 0)));
    busWr(3'd2, 32'h1);
    repeat (200) @(negedge clk);
    busRd(3'd5, d); checkEq("R10 busy waiting", 32'(d[0]), 32'h1);
    checkEq("R10 frames so far", slvFrame, 1);
    checkEq("R10 sclk idle", 32'(sclk), 32'h0);
    busWr(3'd6, 32'(txPat(9, 1)));
    waitIdle();
    checkEq("R10 resumed", slvFrame, 2);
    checkEq("R10 second mosi", 32'(slvCap[1]), 32'(txPat(9, 1)));
    busRd(3'd7, d); checkEq("R10 rx0", d, 32'(slvWord(0)));
    busRd(3'd7, d); checkEq("R10 rx1", d, 32'(slvWord(1)));

    // R11 receive full stall, R9 transmit full
    busWr(3'd2, 32'h0);
    busWr(3'd4, 32'd0); busWr(3'd1, 32'd39);
    slaveReset();
    for (int i = 0; i < 32; i++) busWr(3'd6, 32'(txPat(3, i)));
    busRd(3'd5, d); checkEq("R9 tx full", 32'(d[1]), 32'h1);
    busWr(3'd2, 32'h1);
    repeat (1500) @(negedge clk);
    for (int i = 32; i < 40; i++) busWr(3'd6, 32'(txPat(3, i)));
    repeat (500) @(negedge clk);
    busRd(3'd5, d); checkEq("R11 stalled busy", 32'(d[0]), 32'h1);
    checkEq("R11 frames held", slvFrame, 32);
    for (int i = 0; i < 32; i++) begin
      busRd(3'd7, d);
      if (i == 0 || i == 31) checkEq("R11 order", d, 32'(slvWord(i)));
      else if (d !== 32'(slvWord(i))) checkEq("R11 order", d, 32'(slvWord(i)));
    end
    waitIdle();
    checkEq("R11 all frames", slvFrame, 40);
    for (int i = 32; i < 40; i++) begin
      busRd(3'd7, d);
      if (d !== 32'(slvWord(i)) || i == 39) checkEq("R11 tail", d, 32'(slvWord(i)));
    end
    busRd(3'd5, d); checkEq("R11 drained", 32'(d[2]), 32'h1);

    // R7 select encoding
    busWr(3'd3, 32'h4); checkEq("R7 line 2", 32'(csN), 32'hB);
    busWr(3'd3, 32'h0); checkEq("R7 none", 32'(csN), 32'hF);

    // R12 abort mid frame
    busWr(3'd2, 32'h0);
    busWr(3'd0, 32'h5); busWr(3'd4, 32'd7); busWr(3'd1, 32'd5);
    tbCpol = 1; tbCpha = 0; tbWide = 1; slaveReset();
    busWr(3'd3, 32'h1);
    for (int i = 0; i < 6; i++) busWr(3'd6, 32'(txPat(5, i)));
    busWr(3'd2, 32'h1);
    repeat (40) @(negedge clk);
    busWr(3'd2, 32'h0);
    checkEq("R12 sclk idle", 32'(sclk), 32'h1);
    busRd(3'd5, d); checkEq("R12 busy low", 32'(d[0]), 32'h0);
    k = slvEdgeTotal;
    repeat (100) @(negedge clk);
    checkEq("R12 no edges", slvEdgeTotal, k);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule